// File: doc/BRIEF.md
# Multiprocessor-Mode UART Transmitter

This block serialises bytes onto an asynchronous line and tags every frame with one extra bit. That bit marks the frame as an ID (address) frame or as a data frame. The receivers on a shared line use the tag to find the frames addressed to them. A host writes a holding register, and a busy/empty flag handshake controls when it may do so. A second flag reports when the line has gone quiet. Bit timing comes from a single baud-tick input, which pulses once per bit period.

The host side has no valid/ready pair. The empty flag plays the role of ready: while it reads 1 the holding register accepts a write. The host then clears the flag, which plays the role of valid and hands the byte to the shifter. While the flag reads 0 the block applies back-pressure, and further writes are dropped. When transmit enable is low, the output pin follows a port-level input. Setting that input to 0 and then dropping enable holds the line low as a break.

Top module: `mptx_top`

## Requirements
- R1: A frame is, in order: one start bit at 0, DATA_W data bits with the least significant bit first, the tag bit, then one stop bit at 1. Each bit lasts one baud-tick period, and a new bit appears on `txd` in the cycle after the tick that starts it.
- R2: The tag bit equals the `id_frame` level sampled in the write cycle, so 1 marks an ID frame and 0 marks a data frame.
- R3: After `tx_en` rises, `txd` stays at 1 for DATA_W+3 tick periods. If data is already waiting, the first start bit begins on tick number DATA_W+3, counted from the enable.
- R4: A `wr_stb` is accepted only while `empty` is 1. A write made while `empty` is 0 changes neither the byte nor the tag that is sent.
- R5: A `clr_empty` made while `empty` is 1 drives `empty` to 0 in the next cycle. At the next frame boundary tick the byte and tag move to the shifter, and `empty` reads 1 in the cycle after that tick.
- R6: When data is pending as a stop bit ends, the next start bit follows at once. Consecutive start bits are then exactly DATA_W+3 ticks apart.
- R7: `tend` drops to 0 together with `empty` when the host clears the flag. It returns to 1 once the last stop bit has ended with nothing pending, and `tend` is never 1 while `empty` is 0.
- R8: While `tx_en` is 0, `txd` equals `port_level` in the same cycle, the shifter is reset, and `empty` and `tend` both read 1 one cycle after the drop. With `port_level` at 0 this is a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmit enable |
| port_level | input | 1 | Pin level used while disabled (0 gives a break) |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_byte | input | DATA_W | Byte to load |
| id_frame | input | 1 | Tag for the written byte: 1 for ID, 0 for data |
| clr_empty | input | 1 | Host clears the empty flag, which hands the byte over |
| empty | output | 1 | Holding register may be written |
| tend | output | 1 | Line idle, last frame complete |
| txd | output | 1 | Serial output |

## Verification
The assertions check on every cycle that:
- a load always refills the empty flag;
- `tend` never shows while data is pending;
- a blocked write leaves the holding register untouched;
- the warm-up mark and every stop bit drive the line high;
- disabling the block forces both flags to 1.

Other behaviour only the bench's scenarios can show:
- the bit order and tag value of whole frames;
- the exact tick on which the first start bit follows enable;
- the gapless spacing of a burst of frames;
- the break level on the pin.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  typedef enum logic [1:0] {
    SH_OFF   = 2'd0,
    SH_WARM  = 2'd1,
    SH_IDLE  = 2'd2,
    SH_SHIFT = 2'd3
  } sh_state_t;
endpackage

// File: rtl/mptx_hostreg.sv
module mptx_hostreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              id_frame,
  input  logic              clr_empty,
  input  logic              load,
  input  logic              sh_idle,
  output logic [DATA_W-1:0] hold_byte,
  output logic              hold_tag,
  output logic              empty,
  output logic              tend,
  output logic              pending
);
  logic take_wr;
  logic take_clr;

  assign take_wr  = wr_stb && empty;
  assign take_clr = clr_empty && empty;
  assign pending  = !empty;

  // holding register: writable only while the empty flag is up
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_byte <= '0;
      hold_tag  <= 1'b0;
    end else if (take_wr) begin
      hold_byte <= wr_byte;
      hold_tag  <= id_frame;
    end
  end

  // empty / transmit-end flags
  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      empty <= 1'b1;
      tend  <= 1'b1;
    end else if (take_clr) begin
      empty <= 1'b0;
      tend  <= 1'b0;
    end else begin
      if (load) empty <= 1'b1;
      if (sh_idle && empty) tend <= 1'b1;
    end
  end
endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              pending,
  input  logic [DATA_W-1:0] hold_byte,
  input  logic              hold_tag,
  output logic              load,
  output logic              sh_idle,
  output logic              warm,
  output logic              stop_phase,
  output logic              line
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  sh_state_t             state;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] sr;
  logic                  boundary;

  // a frame boundary: idle tick, or the tick ending the last mark/stop bit
  assign boundary = baud_tick &&
                    ((state == SH_IDLE) ||
                     (((state == SH_WARM) || (state == SH_SHIFT)) && (cnt == LAST)));
  assign load       = tx_en && boundary && pending;
  assign sh_idle    = (state == SH_IDLE);
  assign warm       = (state == SH_WARM);
  assign stop_phase = (state == SH_SHIFT) && (cnt == LAST);
  assign line       = (state == SH_SHIFT) ? sr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      state <= SH_OFF;
      cnt   <= '0;
      sr    <= '1;
    end else begin
      unique case (state)
        SH_OFF: begin
          state <= SH_WARM;
          cnt   <= '0;
        end
        default: begin
          if (boundary) begin
            cnt <= '0;
            if (pending) begin
              sr    <= {1'b1, hold_tag, hold_byte, 1'b0};
              state <= SH_SHIFT;
            end else begin
              sr    <= '1;
              state <= SH_IDLE;
            end
          end else if (baud_tick && (state != SH_IDLE)) begin
            cnt <= cnt + 1'b1;
            if (state == SH_SHIFT) sr <= {1'b1, sr[FRAME_BITS-1:1]};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mptx_top.sv
module mptx_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              port_level,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              id_frame,
  input  logic              clr_empty,
  output logic              empty,
  output logic              tend,
  output logic              txd
);
  logic [DATA_W-1:0] hold_byte_w;
  logic              hold_tag_w;
  logic              pending_w;
  logic              load_w;
  logic              sh_idle_w;
  logic              warm_w;
  logic              stop_phase_w;
  logic              line_w;

  mptx_hostreg #(.DATA_W(DATA_W)) i_hostreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .wr_stb    (wr_stb),
    .wr_byte   (wr_byte),
    .id_frame  (id_frame),
    .clr_empty (clr_empty),
    .load      (load_w),
    .sh_idle   (sh_idle_w),
    .hold_byte (hold_byte_w),
    .hold_tag  (hold_tag_w),
    .empty     (empty),
    .tend      (tend),
    .pending   (pending_w)
  );

  mptx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .baud_tick  (baud_tick),
    .pending    (pending_w),
    .hold_byte  (hold_byte_w),
    .hold_tag   (hold_tag_w),
    .load       (load_w),
    .sh_idle    (sh_idle_w),
    .warm       (warm_w),
    .stop_phase (stop_phase_w),
    .line       (line_w)
  );

  // disabled: the pin falls back to the port level (break when 0)
  assign txd = tx_en ? line_w : port_level;
endmodule

// File: rtl/mptx_chk.sv
module mptx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              txd,
  input logic              empty,
  input logic              tend,
  input logic              wr_stb,
  input logic              load,
  input logic              warm,
  input logic              stop_phase,
  input logic [DATA_W-1:0] hold_byte
);
  a_r5_load_refills_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> empty);

  a_r7_tend_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> empty);

  a_r8_off_flags_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (empty && tend));

  a_r3_warm_mark_high: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && tx_en) |-> txd);

  a_r1_stop_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_phase && tx_en) |-> txd);

  a_r4_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !empty) |=> $stable(hold_byte));
endmodule

bind mptx_top mptx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .txd        (txd),
  .empty      (empty),
  .tend       (tend),
  .wr_stb     (wr_stb),
  .load       (load_w),
  .warm       (warm_w),
  .stop_phase (stop_phase_w),
  .hold_byte  (hold_byte_w)
);

// File: tb/test_mptx_top.sv
`timescale 1ns/1ps
module test_mptx_top;
  localparam int DATA_W   = 8;
  localparam int FRAME    = DATA_W + 3;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_en = 1'b0;
  logic port_level = 1'b1;
  logic wr_stb = 1'b0;
  logic [DATA_W-1:0] wr_byte = '0;
  logic id_frame = 1'b0;
  logic clr_empty = 1'b0;
  logic empty, tend, txd;

  mptx_top #(.DATA_W(DATA_W)) i_mptx_top (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .port_level(port_level), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .id_frame(id_frame), .clr_empty(clr_empty),
    .empty(empty), .tend(tend), .txd(txd)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int div = 0;
  int tick_no = 0;
  bit tick_seen = 1'b0;
  int mon_idx = 0;
  logic [DATA_W:0] got;
  logic [DATA_W:0] exp_q[$];
  int start_ticks[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // tick generator, driven away from the active edge
  always @(negedge clk) begin
    div = (div + 1) % TICK_DIV;
    baud_tick <= (div == TICK_DIV - 1);
  end

  always @(posedge clk) begin
    cyc++;
    tick_seen = baud_tick;
    if (baud_tick) tick_no++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // monitor: decodes frames bit by bit and compares against the scoreboard
  always @(negedge clk) begin
    if (!rst_n || !tx_en) begin
      mon_idx = 0;
    end else if (tick_seen) begin
      if (mon_idx == 0) begin
        if (txd == 1'b0) begin
          mon_idx = 1;
          got = '0;
          start_ticks.push_back(tick_no);
        end
      end else if (mon_idx <= DATA_W + 1) begin
        got[mon_idx-1] = txd;
        mon_idx++;
      end else begin
        chk(txd == 1'b1, "R1 stop bit", 32'(txd), 32'd1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected frame", 32'(got), 32'h0);
        end else begin
          logic [DATA_W:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R1/R2 frame bits and tag", 32'(got), 32'(e));
        end
        mon_idx = 0;
      end
    end
  end

  task automatic wait_empty();
    for (int i = 0; i < 1000 && empty !== 1'b1; i++) @(negedge clk);
  endtask

  // driver: confirm empty, write, clear, push expected item
  task automatic send(input logic [DATA_W-1:0] b, input logic id);
    wait_empty();
    wr_byte = b; id_frame = id; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; clr_empty = 1'b1;
    exp_q.push_back({id, b});
    @(negedge clk);
    clr_empty = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && (exp_q.size() != 0 || mon_idx != 0); i++) @(negedge clk);
  endtask

  task automatic enable();
    @(posedge clk iff baud_tick);
    @(negedge clk);
    tx_en = 1'b1;
    tick_no = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R8 reset empty", 32'(empty), 32'd1);
    chk(tend == 1'b1, "R7 reset tend", 32'(tend), 32'd1);
    chk(txd == 1'b1, "R8 disabled pin follows port", 32'(txd), 32'd1);
    port_level = 1'b0;
    #1;
    chk(txd == 1'b0, "R8 break level", 32'(txd), 32'd0);
    port_level = 1'b1;

    // first frame written during warm-up, plus a blocked write
    enable();
    wr_byte = 8'hA5; id_frame = 1'b1; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; clr_empty = 1'b1;
    exp_q.push_back({1'b1, 8'hA5});
    @(negedge clk);
    clr_empty = 1'b0;
    chk(empty == 1'b0, "R5 empty cleared", 32'(empty), 32'd0);
    chk(tend == 1'b0, "R7 tend cleared", 32'(tend), 32'd0);
    wr_byte = 8'h3C; id_frame = 1'b0; wr_stb = 1'b1;   // R4: must be ignored
    @(negedge clk);
    wr_stb = 1'b0;
    wait_empty();
    chk(tick_no == FRAME, "R5 empty refilled on load tick", 32'(tick_no), 32'(FRAME));
    wait_drain();
    chk(start_ticks.size() == 1 && start_ticks[0] == FRAME, "R3 first start tick",
        32'(start_ticks.size() > 0 ? start_ticks[0] : -1), 32'(FRAME));
    repeat (2 * TICK_DIV) @(negedge clk);
    chk(tend == 1'b1, "R7 tend after single frame", 32'(tend), 32'd1);

    // burst of mixed ID and data frames
    send(8'h5A, 1'b0);
    send(8'h01, 1'b1);
    send(8'hFF, 1'b0);
    send(8'h00, 1'b1);
    chk(tend == 1'b0, "R7 tend low while busy", 32'(tend), 32'd0);
    wait_drain();
    for (int i = 2; i < 5; i++) begin
      if (start_ticks.size() > i)
        chk(start_ticks[i] - start_ticks[i-1] == FRAME, "R6 back-to-back spacing",
            32'(start_ticks[i] - start_ticks[i-1]), 32'(FRAME));
      else
        chk(1'b0, "R6 burst frame missing", 32'(start_ticks.size()), 32'd5);
    end
    repeat (2 * TICK_DIV) @(negedge clk);
    chk(tend == 1'b1, "R7 tend after burst", 32'(tend), 32'd1);

    // disable mid-frame, then break
    send(8'h77, 1'b0);
    void'(exp_q.pop_back());
    repeat (5 * TICK_DIV) @(negedge clk);
    tx_en = 1'b0;
    #1;
    chk(txd == 1'b1, "R8 pin follows port after drop", 32'(txd), 32'd1);
    @(negedge clk);
    chk(empty == 1'b1 && tend == 1'b1, "R8 flags after disable",
        32'({empty, tend}), 32'h3);
    port_level = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R8 break held", 32'(txd), 32'd0);
    chk(exp_q.size() == 0, "R1 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule